// File: doc/BRIEF.md
# External Register Bus Controller

This block turns single-word read and write requests from a processor core into bus cycles on a 16-bit bidirectional data bus. The bus serves up to eight peripheral registers outside the core, such as converter data latches. The controller drives a latched 3-bit register select and a direction line that is low only while the core owns the data pins. It also drives an active-low data strobe and the output enable for the pad drivers of the data pins. A peripheral takes write data on the rising edge of the strobe. On reads, the controller captures the bus on the clock edge that ends the strobe.

Every access runs as a fixed sequence: one setup cycle, one or more strobe cycles, and one hold cycle in which the core receives its acknowledge. A configuration input, captured when the request is accepted, adds a single internal wait cycle to the strobe. After that cycle, an active-high wait input from the peripheral can stretch the strobe further, one clock for each rising edge on which it is seen high.

Top module: `ext_reg_bus`

## Requirements
- R1: While reset is low and right after it is released, ext_ds_n is 1, ext_rnw is 1, ext_oe is 0, cpu_ack is 0 and ext_addr is 0.
- R2: ext_oe is 1 only from the setup cycle through the hold cycle of a write access. It stays 0 while idle and during every read access.
- R3: ext_rnw is 0 from the setup cycle through the hold cycle of a write (the core drives the bus). It is 1 at every other time.
- R4: ext_addr takes the value of cpu_addr on the clock edge that accepts a request (cpu_req high while idle). It holds that value until the next request is accepted.
- R5: ext_addr and ext_rnw are valid for one full clock before ext_ds_n falls. They stay unchanged through the clock that follows the rise of ext_ds_n.
- R6: During a write, ext_dout carries the cpu_wdata captured at acceptance, and it is steady while ext_oe is 1.
- R7: On a read, cpu_rdata takes ext_din as sampled on the rising clock edge at which ext_ds_n is released.
- R8: After any internal wait cycle, each rising edge on which ext_wait is 1 keeps ext_ds_n low for one more clock. With no wait, the strobe lasts exactly one clock.
- R9: When int_wait_en is 1 at acceptance, the strobe is one clock longer, and ext_wait is ignored on that first strobe edge. The strobe therefore lasts 1 + int_wait + (number of effective ext_wait edges) clocks.
- R10: cpu_ack is a one-clock pulse in the clock right after ext_ds_n rises, for reads and writes alike. The next request is accepted no earlier than the clock after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | External register select |
| cpu_wdata | input | 16 | Write data |
| int_wait_en | input | 1 | Insert one internal wait cycle |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Access complete, one-clock pulse |
| ext_addr | output | 3 | Latched register select |
| ext_rnw | output | 1 | Direction: 0 = core drives the bus |
| ext_ds_n | output | 1 | Data strobe, active low |
| ext_oe | output | 1 | Output enable for the data pin drivers |
| ext_dout | output | 16 | Data toward the pins |
| ext_din | input | 16 | Data from the pins |
| ext_wait | input | 1 | Peripheral wait request, active high |

## Verification
The properties assume that int_wait_en keeps its value from the moment a request is accepted until the strobe falls, since the wait-state property reads the live input at the strobe's falling edge. They also assume that cpu_req is released no later than the acknowledge. The directed tasks change both only at the start of an access and drop cpu_req right after acceptance. They drive ext_wait only during strobe cycles, with a set number of effective high edges, and they change ext_din on every strobe cycle so that the read capture edge is pinned down.

// File: rtl/ext_reg_bus.sv
module ext_reg_bus #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          int_wait_en,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ack,
  output logic [AW-1:0] ext_addr,
  output logic          ext_rnw,
  output logic          ext_ds_n,
  output logic          ext_oe,
  output logic [DW-1:0] ext_dout,
  input  logic [DW-1:0] ext_din,
  input  logic          ext_wait
);

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_SETUP = 2'd1;
  localparam logic [1:0] ST_STRB  = 2'd2;
  localparam logic [1:0] ST_HOLD  = 2'd3;

  logic [1:0]    st;
  logic          iws_q;
  logic          rnw_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      iws_q   <= 1'b0;
      rnw_q   <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cpu_req) begin
          st      <= ST_SETUP;
          addr_q  <= cpu_addr;
          rnw_q   <= !cpu_we;
          wdata_q <= cpu_wdata;
          iws_q   <= int_wait_en;
        end
        ST_SETUP: st <= ST_STRB;
        ST_STRB: begin
          if (iws_q) iws_q <= 1'b0;
          else if (!ext_wait) begin
            st <= ST_HOLD;
            if (rnw_q) rdata_q <= ext_din;
          end
        end
        default: begin
          st    <= ST_IDLE;
          rnw_q <= 1'b1;
        end
      endcase
    end
  end

  assign ext_ds_n  = (st != ST_STRB);
  assign ext_rnw   = rnw_q;
  assign ext_oe    = !rnw_q;
  assign ext_addr  = addr_q;
  assign ext_dout  = wdata_q;
  assign cpu_ack   = (st == ST_HOLD);
  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/ext_reg_bus_chk.sv
module ext_reg_bus_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_wait_en,
  input logic          cpu_ack,
  input logic [AW-1:0] ext_addr,
  input logic          ext_rnw,
  input logic          ext_ds_n,
  input logic          ext_oe,
  input logic [DW-1:0] ext_dout,
  input logic          ext_wait
);

  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ext_oe |-> !ext_rnw); // R2
  AST_DOUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (ext_oe && $past(ext_oe)) |-> $stable(ext_dout)); // R6
  AST_SETUP_BEFORE_DS: assert property (@(posedge clk) disable iff (!rst_n) $fell(ext_ds_n) |-> ($stable(ext_addr) && $stable(ext_rnw))); // R5
  AST_HOLD_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n) $rose(ext_ds_n) |-> ($stable(ext_addr) && $stable(ext_rnw))); // R5
  AST_EXT_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n) (!ext_ds_n && $past(!ext_ds_n) && ext_wait) |=> !ext_ds_n); // R8
  AST_INT_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ext_ds_n) && int_wait_en) |=> !ext_ds_n); // R9
  AST_ACK_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n) $rose(ext_ds_n) |-> cpu_ack); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpu_ack |=> (!cpu_ack && ext_ds_n)); // R10

endmodule

bind ext_reg_bus ext_reg_bus_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_wait_en(int_wait_en), .cpu_ack(cpu_ack),
  .ext_addr(ext_addr), .ext_rnw(ext_rnw), .ext_ds_n(ext_ds_n), .ext_oe(ext_oe),
  .ext_dout(ext_dout), .ext_wait(ext_wait)
);

// File: tb/ext_reg_bus_bench.sv
`timescale 1ns/1ps
module ext_reg_bus_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, int_wait_en = 1'b0, ext_wait = 1'b0;
  logic [2:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, ext_din = '0;
  logic [15:0] cpu_rdata, ext_dout;
  logic [2:0]  ext_addr;
  logic        cpu_ack, ext_rnw, ext_ds_n, ext_oe;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_reg_bus u_ext_reg_bus (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .int_wait_en(int_wait_en), .cpu_rdata(cpu_rdata),
    .cpu_ack(cpu_ack), .ext_addr(ext_addr), .ext_rnw(ext_rnw), .ext_ds_n(ext_ds_n),
    .ext_oe(ext_oe), .ext_dout(ext_dout), .ext_din(ext_din), .ext_wait(ext_wait)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic reset_test();
    repeat (2) @(negedge clk);
    chk("R1", "ds_n in reset", ext_ds_n, 1);
    chk("R1", "oe in reset", ext_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ds_n", ext_ds_n, 1);
    chk("R1", "rnw", ext_rnw, 1);
    chk("R1", "oe", ext_oe, 0);
    chk("R1", "ack", cpu_ack, 0);
    chk("R1", "addr", ext_addr, 0);
  endtask

  task automatic access(input logic we, input logic [2:0] a, input logic [15:0] wd,
                        input logic iws, input int waits);
    int n = 0;
    logic [15:0] last_din = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; int_wait_en = iws;
    @(negedge clk);
    cpu_req = 1'b0; cpu_addr = ~a; cpu_wdata = ~wd;
    chk("R5", "ds_n in setup", ext_ds_n, 1);
    chk("R4", "addr in setup", ext_addr, a);
    chk("R3", "rnw in setup", ext_rnw, !we);
    chk("R2", "oe in setup", ext_oe, we);
    @(negedge clk);
    while (ext_ds_n == 1'b0 && n < 40) begin
      ext_wait = (n >= int'(iws)) && ((n - int'(iws)) < waits);
      ext_din  = 16'hA000 + 16'(n) + {13'd0, a};
      last_din = ext_din;
      if (we) chk("R6", "dout during strobe", ext_dout, wd);
      chk("R2", "oe during strobe", ext_oe, we);
      n++;
      @(negedge clk);
    end
    ext_wait = 1'b0;
    chk(iws ? "R9" : "R8", "strobe length", n, 1 + int'(iws) + waits);
    chk("R10", "ack after strobe", cpu_ack, 1);
    chk("R5", "addr held after strobe", ext_addr, a);
    chk("R5", "rnw held after strobe", ext_rnw, !we);
    if (!we) chk("R7", "read data", cpu_rdata, last_din);
    @(negedge clk);
    chk("R10", "ack one pulse", cpu_ack, 0);
    chk("R3", "rnw back high", ext_rnw, 1);
    chk("R2", "oe off after cycle", ext_oe, 0);
    chk("R4", "addr kept while idle", ext_addr, a);
  endtask

  task automatic idle_test();
    repeat (3) @(negedge clk);
    chk("R2", "oe while idle", ext_oe, 0);
    chk("R8", "no strobe without request", ext_ds_n, 1);
  endtask

  initial begin
    reset_test();
    access(1'b1, 3'd5, 16'h1234, 1'b0, 0);
    access(1'b0, 3'd2, 16'h0000, 1'b0, 0);
    access(1'b1, 3'd7, 16'hBEEF, 1'b1, 0);
    access(1'b0, 3'd1, 16'h0000, 1'b1, 0);
    access(1'b1, 3'd3, 16'h5A5A, 1'b0, 3);
    access(1'b0, 3'd6, 16'h0000, 1'b0, 2);
    access(1'b0, 3'd4, 16'h0000, 1'b1, 2);
    access(1'b1, 3'd0, 16'hFFFF, 1'b1, 1);
    idle_test();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule